// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer of a windowed integer register file, together with three occupancy counters: the number of windows that can still be saved into, the number that can be restored from, and the number of clean windows. Each instruction arriving at rename carries a two-bit window request. The block resolves that request in the same cycle. It returns the window number the instruction must use for its register mapping, a two-bit exception code, and a flag that says whether destination and condition-code registers may be mapped at all.

The request is resolved combinationally from the committed state. State changes only on the clock edge where `accept` is high, which means the instruction has entered renaming. On that edge the window pointer takes the resolved window number. The save and restore counters move only when the accepted request raised no exception. Trap entry, spill and fill are handled elsewhere, so the counters are never rebalanced here. The clean-window count therefore keeps its reset value, which is set by a parameter.

Top module: `regwin_ctrl`

## Requirements
- R1: A save request (req_code 1) while the can-save count is zero gives exc_code 1 (window overflow), and win_num stays equal to the current window.
- R2: A save with a nonzero can-save count, where the clean-window count equals the can-restore count, gives exc_code 3 (clean window), and win_num stays equal to the current window.
- R3: A save that raises no exception gives exc_code 0 and win_num = (current + 1) mod NWIN.
- R4: A restore request (req_code 2) while the can-restore count is zero gives exc_code 2 (window underflow) with win_num unchanged. Otherwise it gives exc_code 0 and win_num = (current + NWIN - 1) mod NWIN.
- R5: A flush request (req_code 3) gives exc_code 1 whenever the can-save count differs from NWIN - 2, and exc_code 0 otherwise. In both cases win_num equals the current window.
- R6: dest_en is 0 whenever exc_code is nonzero, and 1 otherwise.
- R7: On an accepted save with no exception, can-save falls by one and can-restore rises by one. An accepted restore with no exception does the reverse. Any exception, and any request without accept, leaves both counters unchanged.
- R8: On a clock edge with accept high, the current window becomes win_num. Without accept it holds. A no-change request (req_code 0) shows the current window on win_num with exc_code 0.
- R9: After reset, the current window is 0, can-save is NWIN - 2, can-restore is 0 and clean-window is CLEAN_INIT (default NWIN - 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_code | input | 2 | Window request: 0 none, 1 save, 2 restore, 3 flush |
| accept | input | 1 | Instruction enters renaming this cycle; commits the request |
| win_num | output | $clog2(NWIN) | Window number the instruction uses |
| exc_code | output | 2 | 0 none, 1 overflow, 2 underflow, 3 clean window |
| dest_en | output | 1 | Destination and condition-code mapping allowed |

## Verification
win_num, exc_code and dest_en depend combinationally on req_code and the registered state. They are therefore due in the same cycle that a request is driven. The bench drives each request just after a falling edge and samples one time unit later, before the next rising edge. The effect of `accept` on the pointer and counters shows up only from the following cycle. The bench observes it through the next request's window number and exception code, for example a no-change request after an unaccepted restore, or a repeated save after a counter returns to zero. A second instance with a small clean-window count reaches the clean-window fault, which the default counters never reach.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_SAVE    = 2'd1,
    REQ_RESTORE = 2'd2,
    REQ_FLUSH   = 2'd3
  } win_req_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_OVF   = 2'd1,
    EXC_UNF   = 2'd2,
    EXC_CLEAN = 2'd3
  } win_exc_e;

  // next window up, wrapping at n
  function automatic int unsigned win_up(int unsigned w, int unsigned n);
    return (w + 1) % n;
  endfunction

  // next window down, wrapping at n
  function automatic int unsigned win_down(int unsigned w, int unsigned n);
    return (w + n - 1) % n;
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned WW = $clog2(NWIN),
  localparam int unsigned CW = $clog2(NWIN)
) (
  input  logic [1:0]    req,
  input  logic [WW-1:0] cwp,
  input  logic [CW-1:0] can_save,
  input  logic [CW-1:0] can_rest,
  input  logic [CW-1:0] clean_cnt,
  output logic [WW-1:0] win,
  output logic [1:0]    exc,
  output logic          dst_ok,
  output logic          save_ok,
  output logic          rest_ok
);

  localparam logic [CW-1:0] FLUSH_FREE = CW'(NWIN - 2);

  always_comb begin
    win     = cwp;
    exc     = EXC_NONE;
    save_ok = 1'b0;
    rest_ok = 1'b0;
    unique case (win_req_e'(req))
      REQ_SAVE: begin
        if (can_save == '0)
          exc = EXC_OVF;
        else if (clean_cnt == can_rest)
          exc = EXC_CLEAN;
        else begin
          win     = WW'(win_up(32'(cwp), NWIN));
          save_ok = 1'b1;
        end
      end
      REQ_RESTORE: begin
        if (can_rest == '0)
          exc = EXC_UNF;
        else begin
          win     = WW'(win_down(32'(cwp), NWIN));
          rest_ok = 1'b1;
        end
      end
      REQ_FLUSH: begin
        if (can_save != FLUSH_FREE)
          exc = EXC_OVF;
      end
      default: ;
    endcase
    dst_ok = (exc == EXC_NONE);
  end

endmodule

// File: rtl/regwin_state.sv
module regwin_state
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CLEAN_INIT = NWIN - 1,
  localparam int unsigned WW = $clog2(NWIN),
  localparam int unsigned CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [WW-1:0] win_in,
  input  logic          do_save,
  input  logic          do_rest,
  output logic [WW-1:0] cwp,
  output logic [CW-1:0] can_save,
  output logic [CW-1:0] can_rest,
  output logic [CW-1:0] clean_cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp       <= '0;
      can_save  <= CW'(NWIN - 2);
      can_rest  <= '0;
      clean_cnt <= CW'(CLEAN_INIT);
    end else begin
      clean_cnt <= clean_cnt;
      if (commit) begin
        cwp <= win_in;
        if (do_save) begin
          can_save <= can_save - 1'b1;
          can_rest <= can_rest + 1'b1;
        end else if (do_rest) begin
          can_save <= can_save + 1'b1;
          can_rest <= can_rest - 1'b1;
        end
      end
    end
  end

  // R7: save and restore counts always share NWIN-2 windows
  a_r7_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(can_save) + 32'(can_rest)) == NWIN - 2);

  // R7: without a commit the counters hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(can_save) && $stable(can_rest));

  // R8: pointer follows the committed window number
  a_r8_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cwp == $past(win_in));

  // R8: pointer holds without a commit
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cwp));

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CLEAN_INIT = NWIN - 1,
  localparam int unsigned WW = $clog2(NWIN),
  localparam int unsigned CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_code,
  input  logic          accept,
  output logic [WW-1:0] win_num,
  output logic [1:0]    exc_code,
  output logic          dest_en
);

  logic [WW-1:0] cwp_q;
  logic [CW-1:0] can_save_q, can_rest_q, clean_q;
  logic          save_ok, rest_ok;
  logic          do_save, do_rest;

  regwin_decode #(.NWIN(NWIN)) u_decode (
    .req       (req_code),
    .cwp       (cwp_q),
    .can_save  (can_save_q),
    .can_rest  (can_rest_q),
    .clean_cnt (clean_q),
    .win       (win_num),
    .exc       (exc_code),
    .dst_ok    (dest_en),
    .save_ok   (save_ok),
    .rest_ok   (rest_ok)
  );

  assign do_save = accept & save_ok;
  assign do_rest = accept & rest_ok;

  regwin_state #(.NWIN(NWIN), .CLEAN_INIT(CLEAN_INIT)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (accept),
    .win_in    (win_num),
    .do_save   (do_save),
    .do_rest   (do_rest),
    .cwp       (cwp_q),
    .can_save  (can_save_q),
    .can_rest  (can_rest_q),
    .clean_cnt (clean_q)
  );

  // R1: save with no free window faults and keeps the window
  a_r1_save_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == REQ_SAVE && can_save_q == '0) |-> (exc_code == EXC_OVF && win_num == cwp_q));

  // R3: good save moves exactly one window up
  a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == REQ_SAVE && exc_code == EXC_NONE) |->
      win_num == ((cwp_q == WW'(NWIN - 1)) ? '0 : cwp_q + 1'b1));

  // R4: good restore moves exactly one window down
  a_r4_rest_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code == REQ_RESTORE && can_rest_q != '0) |->
      (exc_code == EXC_NONE && win_num == ((cwp_q == '0) ? WW'(NWIN - 1) : cwp_q - 1'b1)));

  // R5: flush never moves the window
  a_r5_flush_still: assert property (@(posedge clk) disable iff (!rst_n)
    req_code == REQ_FLUSH |-> win_num == cwp_q);

  // R6: faults block destination mapping
  a_r6_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code != EXC_NONE |-> !dest_en);

  // R7: a fault never moves the counters
  a_r7_fault_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exc_code != EXC_NONE) |=> $stable(can_save_q));

endmodule

// File: tb/regwin_ctrl_bench.sv
module regwin_ctrl_bench;

  localparam int NV = 26;
  // {req[8:7], acc[6], win[5:3], exc[2:1], dest[0]}
  localparam logic [8:0] VEC [NV] = '{
    {2'd2, 1'b1, 3'd0, 2'd2, 1'b0},  // restore at reset: underflow
    {2'd0, 1'b1, 3'd0, 2'd0, 1'b1},  // none
    {2'd3, 1'b1, 3'd0, 2'd0, 1'b1},  // flush, all free
    {2'd1, 1'b1, 3'd1, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd2, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd3, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd4, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd5, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd6, 2'd0, 1'b1},
    {2'd3, 1'b1, 3'd6, 2'd1, 1'b0},  // flush, none free
    {2'd1, 1'b1, 3'd6, 2'd1, 1'b0},  // save, full
    {2'd2, 1'b0, 3'd5, 2'd0, 1'b1},  // restore, not accepted
    {2'd0, 1'b1, 3'd6, 2'd0, 1'b1},  // pointer held
    {2'd2, 1'b1, 3'd5, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd6, 2'd0, 1'b1},
    {2'd1, 1'b1, 3'd6, 2'd1, 1'b0},  // full again: counters moved
    {2'd2, 1'b1, 3'd5, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd4, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd3, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd2, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd1, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd0, 2'd0, 1'b1},
    {2'd2, 1'b1, 3'd0, 2'd2, 1'b0},  // empty again
    {2'd3, 1'b1, 3'd0, 2'd0, 1'b1},
    {2'd1, 1'b0, 3'd1, 2'd0, 1'b1},  // save, not accepted
    {2'd0, 1'b1, 3'd0, 2'd0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] req_code, c_req;
  logic       accept, c_acc;
  logic [2:0] win_num, c_win;
  logic [1:0] exc_code, c_exc;
  logic       dest_en, c_dest;
  int         n_checks = 0;
  int         n_errors = 0;

  always #4 clk = ~clk;

  regwin_ctrl u_regwin_ctrl (
    .clk(clk), .rst_n(rst_n), .req_code(req_code), .accept(accept),
    .win_num(win_num), .exc_code(exc_code), .dest_en(dest_en));

  regwin_ctrl #(.NWIN(8), .CLEAN_INIT(2)) u_regwin_ctrl_clean (
    .clk(clk), .rst_n(rst_n), .req_code(c_req), .accept(c_acc),
    .win_num(c_win), .exc_code(c_exc), .dest_en(c_dest));

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  function automatic string tag_of(logic [1:0] r, logic [1:0] e);
    if (r == 2'd1 && e == 2'd1) return "R1";
    if (r == 2'd1 && e == 2'd3) return "R2";
    if (r == 2'd1) return "R3";
    if (r == 2'd2) return "R4";
    if (r == 2'd3) return "R5";
    return "R8";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_code = 2'd0; accept = 1'b0; c_req = 2'd0; c_acc = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(logic [1:0] r, logic a);
    @(negedge clk);
    req_code = r; accept = a;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R9: reset state seen through a none and a flush request
    step(2'd0, 1'b0);
    check("R9", "win", int'(win_num), 0);
    check("R9", "exc", int'(exc_code), 0);
    step(2'd3, 1'b0);
    check("R9", "flush exc", int'(exc_code), 0);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      string t;
      v = VEC[i];
      step(v[8:7], v[6]);
      t = tag_of(v[8:7], v[2:1]);
      check(t, "win", int'(win_num), int'(v[5:3]));
      check(t, "exc", int'(exc_code), int'(v[2:1]));
      check("R6", "dest", int'(dest_en), int'(v[0]));
    end

    // R7: one accepted save makes a restore legal afterwards
    do_reset();
    step(2'd1, 1'b1);
    step(2'd2, 1'b0);
    check("R7", "restore exc", int'(exc_code), 0);
    check("R7", "restore win", int'(win_num), 0);
    // R7: a faulting request leaves the counters alone
    step(2'd2, 1'b1);
    step(2'd2, 1'b1);
    check("R7", "after fault exc", int'(exc_code), 2);

    // R2: clean-window fault on the instance with two clean windows
    @(negedge clk);
    req_code = 2'd0; accept = 1'b0;
    c_req = 2'd1; c_acc = 1'b1;
    #1 check("R3", "clean inst win", int'(c_win), 1);
    @(negedge clk); #1;
    check("R3", "clean inst win", int'(c_win), 2);
    @(negedge clk); #1;
    check("R2", "clean exc", int'(c_exc), 3);
    check("R2", "clean win", int'(c_win), 2);
    check("R6", "clean dest", int'(c_dest), 0);
    @(negedge clk); #1;
    check("R7", "clean held", int'(c_exc), 3);
    c_req = 2'd2;
    #1 check("R4", "clean inst restore", int'(c_win), 1);
    @(negedge clk);
    c_acc = 1'b0;
    finish_run();
  end

endmodule